// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Register Block

This block holds the software-visible state of an interrupt controller with 96 level-sensitive request lines, grouped into three banks of 32. For every line it keeps a pending bit, a mask bit, a class bit that routes the line to the fast (FIQ) or normal (IRQ) path, and a 6-bit priority. A sticky software-request register per bank can raise lines without any hardware input. The block presents the masked pending vectors for each class, the priorities, the global mask level and one-cycle re-arm pulses to a separate priority arbiter. It reads back the arbiter's current winners through two identification-style registers.

Software talks to it with single 32-bit word accesses on a simple request/response bus. A request is taken in one cycle and answered exactly one cycle later with read data and an error flag. Each bank has a block of eight words. Masks are changed whole, or through write-one-to-clear and write-one-to-set aliases. Each line's priority and class sit in a separate word region. A write to the configuration register can return the whole block to its reset state.

Top module: `intc_regs`

## Requirements
- R1: After reset, and one cycle after a write of 1 to bit 1 of the configuration word at 0x010, every bank mask reads all ones. Pending, software, class and priority state all read zero, and the global mask, autoidle and idle fields read zero.
- R2: A line whose input goes from 0 to 1 sets its pending bit at the clock edge that samples the new level. The bank's raw input levels read at bank offset +0x00. Bank base addresses are 0x080 + 0x20 × bank.
- R3: When any input of a bank falls, that bank's pending vector becomes its current inputs OR its software-request bits.
- R4: Bank offset +0x04 reads and writes the mask. A 1 written at +0x08 clears that mask bit, and a 1 written at +0x0C sets it. Both alias words read as 0.
- R5: A write at bank offset +0x10 ORs the value into the software-request register and into pending. A read there returns the software-request register.
- R6: A write at bank offset +0x14 clears the software bits that are written as 1. Pending then becomes the remaining software bits AND the current inputs. The word reads as 0.
- R7: Bank offset +0x18 reads pending AND NOT mask AND NOT class, and offset +0x1C reads pending AND NOT mask AND class. The same vectors drive pend_irq_o and pend_fiq_o.
- R8: In the control word at 0x048, a write sets the global mask from bit 2. A 1 in bit 1 gives a one-cycle FIQ re-arm pulse, and a 1 in bit 0 gives a one-cycle IRQ re-arm pulse. A read returns the global mask in bit 2 only.
- R9: The word at 0x100 + 4 × line (lines 0 to 95) holds the priority in bits [7:2] and the class in bit 0 (1 = FIQ). It reads back in the same layout, and the priority appears on prio_o[line*6 +: 6].
- R10: Offset 0x000 reads 0x21 and 0x014 reads 1. Offset 0x04C reads 0. Offsets 0x040 and 0x044 return win_irq_num and win_fiq_num, and reading them changes no state.
- R11: Bit 0 of the configuration word at 0x010 is autoidle and reads back. The idle word at 0x050 keeps bits [1:0] of what is written.
- R12: A misaligned address, a bank index of 3 (0x0E0–0x0FF), a line word past line 95 or any unmapped offset gives resp_err with read data 0. Such a write changes no state.
- R13: Every accepted request gets resp_valid exactly one cycle later, and no response comes without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_rdata | output | 32 | Read data (0 for writes and errors) |
| resp_err | output | 1 | Access to a non-existent word |
| irq_in | input | 96 | Level-sensitive request lines |
| win_irq_num | input | 8 | Current IRQ winner from the arbiter |
| win_fiq_num | input | 8 | Current FIQ winner from the arbiter |
| pend_irq_o | output | 96 | Unmasked pending lines of IRQ class |
| pend_fiq_o | output | 96 | Unmasked pending lines of FIQ class |
| prio_o | output | 576 | Six-bit priority per line |
| gmask_o | output | 1 | Global mask level |
| rearm_irq_o | output | 1 | One-cycle IRQ re-arm pulse |
| rearm_fiq_o | output | 1 | One-cycle FIQ re-arm pulse |

## Verification
Several properties are checked on every cycle. A rising input always lands in pending. A falling input rebuilds the bank's pending vector from inputs and software bits. A software clear never leaves pending outside the software bits. Mask aliases and soft reset have their effect one cycle later, priority writes land in the addressed line, and the global mask follows each control write. The response comes one cycle after each request, and bad addresses raise the error flag. Some behaviour only the bench scenarios can show: the exact address decoding of each word, the read-back layouts, the per-class pending views after a class change, and the order in which a software clear and a live input interact.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    // Decoded meaning of one word address
    typedef enum logic [4:0] {
        K_BAD,
        K_REV,
        K_SYSCFG,
        K_SYSSTAT,
        K_WIN_IRQ,
        K_WIN_FIQ,
        K_CTRL,
        K_PROT,
        K_IDLE,
        K_B_IN,
        K_B_MASK,
        K_B_MCLR,
        K_B_MSET,
        K_B_SSET,
        K_B_SCLR,
        K_B_PIRQ,
        K_B_PFIQ,
        K_LINE
    } acc_kind_e;

    // Global (non-bank) register state of the block
    typedef struct packed {
        logic              gmask;
        logic              autoidle;
        logic [1:0]        idle;
        logic              rearm_irq;
        logic              rearm_fiq;
        logic              resp_valid;
        logic              resp_err;
        logic [DATA_W-1:0] rdata;
    } ctl_state_t;

endpackage

// File: rtl/intc_decode.sv
module intc_decode
    import intc_pkg::*;
#(
    parameter int NBANK  = 3,
    parameter int BANK_W = 32,
    localparam int NLINES = NBANK * BANK_W,
    localparam int LW     = $clog2(NLINES)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [1:0]        bank,
    output logic [LW-1:0]     line
);

    logic [ADDR_W-3:0] line_off;

    always_comb begin
        kind     = K_BAD;
        bank     = addr[6:5];
        line     = '0;
        line_off = addr[ADDR_W-1:2] - (ADDR_W-2)'(64);
        if (addr[1:0] != 2'b00) begin
            kind = K_BAD;
        end else if (addr[ADDR_W-1:7] == (ADDR_W-7)'(1)) begin
            if (32'(addr[6:5]) < NBANK) begin
                case (addr[4:2])
                    3'd0:    kind = K_B_IN;
                    3'd1:    kind = K_B_MASK;
                    3'd2:    kind = K_B_MCLR;
                    3'd3:    kind = K_B_MSET;
                    3'd4:    kind = K_B_SSET;
                    3'd5:    kind = K_B_SCLR;
                    3'd6:    kind = K_B_PIRQ;
                    default: kind = K_B_PFIQ;
                endcase
            end
        end else if (addr[ADDR_W-1:8] != '0) begin
            if (32'(line_off) < NLINES) begin
                kind = K_LINE;
                line = LW'(line_off);
            end
        end else begin
            case (addr[7:0])
                8'h00:   kind = K_REV;
                8'h10:   kind = K_SYSCFG;
                8'h14:   kind = K_SYSSTAT;
                8'h40:   kind = K_WIN_IRQ;
                8'h44:   kind = K_WIN_FIQ;
                8'h48:   kind = K_CTRL;
                8'h4C:   kind = K_PROT;
                8'h50:   kind = K_IDLE;
                default: kind = K_BAD;
            endcase
        end
    end

endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int W = 32,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic [W-1:0]  irq_in,
    input  logic          wr_mask,
    input  logic          wr_mclr,
    input  logic          wr_mset,
    input  logic          wr_sset,
    input  logic          wr_sclr,
    input  logic [W-1:0]  wdata,
    input  logic          cls_we,
    input  logic [IW-1:0] cls_idx,
    input  logic          cls_val,
    output logic [W-1:0]  in_q,
    output logic [W-1:0]  mask_q,
    output logic [W-1:0]  swi_q,
    output logic [W-1:0]  pend_q,
    output logic [W-1:0]  cls_q
);

    typedef struct packed {
        logic [W-1:0] lvl;
        logic [W-1:0] pend;
        logic [W-1:0] mask;
        logic [W-1:0] swi;
        logic [W-1:0] cls;
    } bank_t;

    bank_t s_d, s_q;
    logic [W-1:0] rise, fall;

    always_comb begin
        s_d      = s_q;
        s_d.lvl  = irq_in;
        rise     = irq_in & ~s_q.lvl;
        fall     = s_q.lvl & ~irq_in;
        // a drop rebuilds the whole bank from live levels and software bits
        if (|fall) s_d.pend = irq_in | s_q.swi;
        else       s_d.pend = s_q.pend | rise;
        if (wr_mask) s_d.mask = wdata;
        if (wr_mclr) s_d.mask = s_q.mask & ~wdata;
        if (wr_mset) s_d.mask = s_q.mask | wdata;
        if (wr_sset) begin
            s_d.swi  = s_q.swi | wdata;
            s_d.pend = s_d.pend | wdata;
        end
        if (wr_sclr) begin
            s_d.swi  = s_q.swi & ~wdata;
            s_d.pend = s_d.swi & irq_in;
        end
        if (cls_we) s_d.cls[cls_idx] = cls_val;
        if (soft_rst) begin
            s_d.pend = '0;
            s_d.mask = '1;
            s_d.swi  = '0;
            s_d.cls  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.lvl  <= '0;
            s_q.pend <= '0;
            s_q.mask <= '1;
            s_q.swi  <= '0;
            s_q.cls  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_q   = s_q.lvl;
    assign mask_q = s_q.mask;
    assign swi_q  = s_q.swi;
    assign pend_q = s_q.pend;
    assign cls_q  = s_q.cls;

    AST_RISE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && !wr_sclr) |=>
        ((pend_q & $past(irq_in & ~in_q)) == $past(irq_in & ~in_q))); // R2

    AST_DROP_RECOMPUTE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(in_q & ~irq_in)) && !soft_rst && !wr_sset && !wr_sclr) |=>
        (pend_q == $past(irq_in | swi_q))); // R3

    AST_MSET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mset && !soft_rst) |=> ((mask_q & $past(wdata)) == $past(wdata))); // R4

    AST_MCLR_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mclr && !soft_rst) |=> ((mask_q & $past(wdata)) == '0)); // R4

    AST_SCLR_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sclr && !soft_rst) |=> ((pend_q & ~swi_q) == '0)); // R6

    AST_SOFT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mask_q == '1 && pend_q == '0 && swi_q == '0 && cls_q == '0)); // R1

endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N  = 96,
    parameter int PW = 6,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          we,
    input  logic [LW-1:0] idx,
    input  logic [PW-1:0] val,
    output logic [N*PW-1:0] prio_flat
);

    logic [N-1:0][PW-1:0] prio_d, prio_q;

    always_comb begin
        prio_d = prio_q;
        if (soft_rst)  prio_d = '0;
        else if (we)   prio_d[idx] = val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prio_q <= '0;
        else        prio_q <= prio_d;
    end

    assign prio_flat = prio_q;

    AST_PRIO_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !soft_rst) |=> (prio_q[$past(idx)] == $past(val))); // R9

endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int          NBANK    = 3,
    parameter int          BANK_W   = 32,
    parameter int          PRIO_W   = 6,
    parameter int          WIN_W    = 8,
    parameter logic [7:0]  REVISION = 8'h21,
    localparam int NLINES = NBANK * BANK_W,
    localparam int LW     = $clog2(NLINES),
    localparam int LB     = $clog2(BANK_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     resp_valid,
    output logic [DATA_W-1:0]        resp_rdata,
    output logic                     resp_err,
    input  logic [NLINES-1:0]        irq_in,
    input  logic [WIN_W-1:0]         win_irq_num,
    input  logic [WIN_W-1:0]         win_fiq_num,
    output logic [NLINES-1:0]        pend_irq_o,
    output logic [NLINES-1:0]        pend_fiq_o,
    output logic [NLINES*PRIO_W-1:0] prio_o,
    output logic                     gmask_o,
    output logic                     rearm_irq_o,
    output logic                     rearm_fiq_o
);

    acc_kind_e     kind;
    logic [1:0]    dec_bank;
    logic [LW-1:0] dec_line;
    logic          acc_wr, soft_rst;

    intc_decode #(.NBANK(NBANK), .BANK_W(BANK_W)) u_dec (
        .addr (req_addr),
        .kind (kind),
        .bank (dec_bank),
        .line (dec_line)
    );

    assign acc_wr   = req_valid && req_write;
    assign soft_rst = acc_wr && (kind == K_SYSCFG) && req_wdata[1];

    logic [NBANK-1:0][BANK_W-1:0] in_v, mask_v, swi_v, pend_v, cls_v;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic sel, line_here;
        assign sel       = (32'(dec_bank) == b);
        assign line_here = (kind == K_LINE) && (32'(dec_line >> LB) == b);

        intc_bank #(.W(BANK_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .irq_in   (irq_in[b*BANK_W +: BANK_W]),
            .wr_mask  (acc_wr && sel && kind == K_B_MASK),
            .wr_mclr  (acc_wr && sel && kind == K_B_MCLR),
            .wr_mset  (acc_wr && sel && kind == K_B_MSET),
            .wr_sset  (acc_wr && sel && kind == K_B_SSET),
            .wr_sclr  (acc_wr && sel && kind == K_B_SCLR),
            .wdata    (req_wdata[BANK_W-1:0]),
            .cls_we   (acc_wr && line_here),
            .cls_idx  (dec_line[LB-1:0]),
            .cls_val  (req_wdata[0]),
            .in_q     (in_v[b]),
            .mask_q   (mask_v[b]),
            .swi_q    (swi_v[b]),
            .pend_q   (pend_v[b]),
            .cls_q    (cls_v[b])
        );
    end

    intc_prio #(.N(NLINES), .PW(PRIO_W)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .we        (acc_wr && kind == K_LINE),
        .idx       (dec_line),
        .val       (req_wdata[PRIO_W+1:2]),
        .prio_flat (prio_o)
    );

    logic [NLINES-1:0] pend_f, mask_f, cls_f;
    assign pend_f     = pend_v;
    assign mask_f     = mask_v;
    assign cls_f      = cls_v;
    assign pend_irq_o = pend_f & ~mask_f & ~cls_f;
    assign pend_fiq_o = pend_f & ~mask_f & cls_f;

    // read multiplexer
    logic [BANK_W-1:0] b_in, b_mask, b_swi, b_pend, b_cls;
    logic [DATA_W-1:0] rd_mux;
    ctl_state_t        c_d, c_q;

    always_comb begin
        b_in = '0; b_mask = '0; b_swi = '0; b_pend = '0; b_cls = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (32'(dec_bank) == b) begin
                b_in   = in_v[b];
                b_mask = mask_v[b];
                b_swi  = swi_v[b];
                b_pend = pend_v[b];
                b_cls  = cls_v[b];
            end
        end
        case (kind)
            K_REV:     rd_mux = DATA_W'(REVISION);
            K_SYSCFG:  rd_mux = DATA_W'(c_q.autoidle);
            K_SYSSTAT: rd_mux = DATA_W'(1);
            K_WIN_IRQ: rd_mux = DATA_W'(win_irq_num);
            K_WIN_FIQ: rd_mux = DATA_W'(win_fiq_num);
            K_CTRL:    rd_mux = DATA_W'({c_q.gmask, 2'b00});
            K_IDLE:    rd_mux = DATA_W'(c_q.idle);
            K_B_IN:    rd_mux = DATA_W'(b_in);
            K_B_MASK:  rd_mux = DATA_W'(b_mask);
            K_B_SSET:  rd_mux = DATA_W'(b_swi);
            K_B_PIRQ:  rd_mux = DATA_W'(b_pend & ~b_mask & ~b_cls);
            K_B_PFIQ:  rd_mux = DATA_W'(b_pend & ~b_mask & b_cls);
            K_LINE:    rd_mux = DATA_W'({prio_o[32'(dec_line)*PRIO_W +: PRIO_W], 1'b0,
                                         cls_f[dec_line]});
            default:   rd_mux = '0;
        endcase
    end

    always_comb begin
        c_d            = c_q;
        c_d.rearm_irq  = 1'b0;
        c_d.rearm_fiq  = 1'b0;
        c_d.resp_valid = req_valid;
        c_d.resp_err   = 1'b0;
        c_d.rdata      = '0;
        if (req_valid) begin
            if (kind == K_BAD) begin
                c_d.resp_err = 1'b1;
            end else if (req_write) begin
                case (kind)
                    K_SYSCFG: begin
                        c_d.autoidle = req_wdata[0];
                        if (req_wdata[1]) begin
                            c_d.autoidle = 1'b0;
                            c_d.idle     = '0;
                            c_d.gmask    = 1'b0;
                        end
                    end
                    K_CTRL: begin
                        c_d.gmask     = req_wdata[2];
                        c_d.rearm_fiq = req_wdata[1];
                        c_d.rearm_irq = req_wdata[0];
                    end
                    K_IDLE:  c_d.idle = req_wdata[1:0];
                    default: ;
                endcase
            end else begin
                c_d.rdata = rd_mux;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign resp_valid  = c_q.resp_valid;
    assign resp_rdata  = c_q.rdata;
    assign resp_err    = c_q.resp_err;
    assign gmask_o     = c_q.gmask;
    assign rearm_irq_o = c_q.rearm_irq;
    assign rearm_fiq_o = c_q.rearm_fiq;

    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R13

    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid); // R13

    AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && kind == K_BAD) |=> (resp_err && resp_rdata == '0)); // R12

    AST_GMASK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && kind == K_CTRL) |=> (gmask_o == $past(req_wdata[2]))); // R8

    AST_REARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm_irq_o || rearm_fiq_o) |-> $past(acc_wr && kind == K_CTRL)); // R8

endmodule

// File: tb/intc_regs_test.sv
module intc_regs_test;

    localparam int NL = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          resp_valid, resp_err;
    logic [31:0]   resp_rdata;
    logic [NL-1:0] irq_in = '0;
    logic [7:0]    win_irq_num = 8'h2A, win_fiq_num = 8'h15;
    logic [NL-1:0] pend_irq_o, pend_fiq_o;
    logic [NL*6-1:0] prio_o;
    logic          gmask_o, rearm_irq_o, rearm_fiq_o;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk; // 200 MHz

    intc_regs uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .resp_err(resp_err), .irq_in(irq_in), .win_irq_num(win_irq_num),
        .win_fiq_num(win_fiq_num), .pend_irq_o(pend_irq_o), .pend_fiq_o(pend_fiq_o),
        .prio_o(prio_o), .gmask_o(gmask_o), .rearm_irq_o(rearm_irq_o),
        .rearm_fiq_o(rearm_fiq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h084, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd1},   // R1 bank0 mask
        '{1'b0, 12'h0A4, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd1},   // R1 bank1 mask
        '{1'b0, 12'h0C4, 32'h0, 32'hFFFF_FFFF, 1'b0, 4'd1},   // R1 bank2 mask
        '{1'b0, 12'h000, 32'h0, 32'h0000_0021, 1'b0, 4'd10},  // R10 revision
        '{1'b0, 12'h014, 32'h0, 32'h0000_0001, 1'b0, 4'd10},  // R10 reset done
        '{1'b0, 12'h04C, 32'h0, 32'h0000_0000, 1'b0, 4'd10},  // R10 protection
        '{1'b0, 12'h040, 32'h0, 32'h0000_002A, 1'b0, 4'd10},  // R10 irq winner
        '{1'b0, 12'h044, 32'h0, 32'h0000_0015, 1'b0, 4'd10},  // R10 fiq winner
        '{1'b1, 12'h088, 32'h0000_00FF, 32'h0, 1'b0, 4'd4},   // R4 clear alias
        '{1'b0, 12'h084, 32'h0, 32'hFFFF_FF00, 1'b0, 4'd4},
        '{1'b0, 12'h088, 32'h0, 32'h0000_0000, 1'b0, 4'd4},
        '{1'b1, 12'h08C, 32'h0000_000F, 32'h0, 1'b0, 4'd4},   // R4 set alias
        '{1'b0, 12'h084, 32'h0, 32'hFFFF_FF0F, 1'b0, 4'd4},
        '{1'b0, 12'h08C, 32'h0, 32'h0000_0000, 1'b0, 4'd4},
        '{1'b1, 12'h090, 32'h0000_0030, 32'h0, 1'b0, 4'd5},   // R5 software set
        '{1'b0, 12'h090, 32'h0, 32'h0000_0030, 1'b0, 4'd5},
        '{1'b0, 12'h098, 32'h0, 32'h0000_0030, 1'b0, 4'd7},   // R7 irq view
        '{1'b0, 12'h09C, 32'h0, 32'h0000_0000, 1'b0, 4'd7},
        '{1'b1, 12'h114, 32'h0000_00FD, 32'h0, 1'b0, 4'd9},   // R9 line 5 prio 63 fiq
        '{1'b0, 12'h114, 32'h0, 32'h0000_00FD, 1'b0, 4'd9},
        '{1'b0, 12'h09C, 32'h0, 32'h0000_0020, 1'b0, 4'd7},   // R7 line 5 now fiq
        '{1'b0, 12'h098, 32'h0, 32'h0000_0010, 1'b0, 4'd7},
        '{1'b1, 12'h094, 32'h0000_0030, 32'h0, 1'b0, 4'd6},   // R6 software clear
        '{1'b0, 12'h098, 32'h0, 32'h0000_0000, 1'b0, 4'd6},
        '{1'b0, 12'h090, 32'h0, 32'h0000_0000, 1'b0, 4'd6},
        '{1'b1, 12'h048, 32'h0000_0004, 32'h0, 1'b0, 4'd8},   // R8 global mask
        '{1'b0, 12'h048, 32'h0, 32'h0000_0004, 1'b0, 4'd8},
        '{1'b1, 12'h048, 32'h0000_0000, 32'h0, 1'b0, 4'd8},
        '{1'b0, 12'h048, 32'h0, 32'h0000_0000, 1'b0, 4'd8},
        '{1'b1, 12'h050, 32'h0000_0007, 32'h0, 1'b0, 4'd11},  // R11 idle
        '{1'b0, 12'h050, 32'h0, 32'h0000_0003, 1'b0, 4'd11},
        '{1'b1, 12'h010, 32'h0000_0001, 32'h0, 1'b0, 4'd11},  // R11 autoidle
        '{1'b0, 12'h010, 32'h0, 32'h0000_0001, 1'b0, 4'd11},
        '{1'b0, 12'h0E0, 32'h0, 32'h0000_0000, 1'b1, 4'd12},  // R12 bank 3
        '{1'b0, 12'h280, 32'h0, 32'h0000_0000, 1'b1, 4'd12},  // R12 line 96
        '{1'b0, 12'h00C, 32'h0, 32'h0000_0000, 1'b1, 4'd12},  // R12 unmapped
        '{1'b0, 12'h102, 32'h0, 32'h0000_0000, 1'b1, 4'd12},  // R12 misaligned
        '{1'b1, 12'h0E4, 32'hFFFF_FFFF, 32'h0, 1'b1, 4'd12},  // R12 bad write
        '{1'b0, 12'h084, 32'h0, 32'hFFFF_FF0F, 1'b0, 4'd12},  // R12 no state change
        '{1'b0, 12'h27C, 32'h0, 32'h0000_0000, 1'b0, 4'd9}    // R9 last line valid
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic er, output logic vl);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        rd = resp_rdata; er = resp_err; vl = resp_valid;
    endtask

    task automatic rd_chk(input int req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic er, vl;
        access(1'b0, a, 32'h0, rd, er, vl);
        check(req, $sformatf("read %h", a), {rd[31:2], er, vl}, {exp[31:2], 1'b0, 1'b1});
        check(req, $sformatf("read %h low", a), 32'(rd[1:0]), 32'(exp[1:0]));
    endtask

    task automatic wr_do(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd; logic er, vl;
        access(1'b1, a, d, rd, er, vl);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd; logic er, vl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        check(1, "gmask after reset", 32'(gmask_o), 32'h0);
        check(1, "pend_irq after reset", 32'(|pend_irq_o), 32'h0);
        check(1, "prio after reset", 32'(|prio_o), 32'h0);
        check(13, "no resp without request", 32'(resp_valid), 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].data, rd, er, vl);
            if (VECS[i].wr) rd = VECS[i].exp;
            check(int'(VECS[i].req), $sformatf("vector %0d addr %h data/err/valid", i, VECS[i].addr),
                  {rd[31:0] ^ VECS[i].exp} | {30'b0, er ^ VECS[i].err, ~vl}, 32'h0);
        end

        // R9 priority on the arbiter port
        check(9, "prio_o line 5", 32'(prio_o[5*6 +: 6]), 32'h3F);

        // R2 rising input on line 40 (bank1 bit 8), R7 view on port
        wr_do(12'h0A8, 32'h0000_0300);
        @(negedge clk); irq_in[40] = 1'b1;
        rd_chk(2, 12'h0A0, 32'h0000_0100);
        rd_chk(2, 12'h0B8, 32'h0000_0100);
        check(7, "pend_irq_o line 40", 32'(pend_irq_o[40]), 32'h1);
        check(7, "pend_fiq_o line 40", 32'(pend_fiq_o[40]), 32'h0);
        // R5 software bit 9 of bank1, R3 drop of line 40
        wr_do(12'h0B0, 32'h0000_0200);
        rd_chk(5, 12'h0B8, 32'h0000_0300);
        @(negedge clk); irq_in[40] = 1'b0;
        @(negedge clk);
        rd_chk(3, 12'h0B8, 32'h0000_0200);
        // R6 software clear while input is high
        @(negedge clk); irq_in[41] = 1'b1;
        wr_do(12'h0B4, 32'h0000_0000);
        rd_chk(6, 12'h0B8, 32'h0000_0200);
        wr_do(12'h0B4, 32'h0000_0200);
        rd_chk(6, 12'h0B8, 32'h0000_0000);
        rd_chk(6, 12'h0B4, 32'h0000_0000);
        @(negedge clk); irq_in[41] = 1'b0;

        // R8 re-arm pulses last one cycle
        access(1'b1, 12'h048, 32'h0000_0007, rd, er, vl);
        check(8, "rearm pulses", {30'b0, rearm_fiq_o, rearm_irq_o}, 32'h3);
        check(8, "gmask_o set", 32'(gmask_o), 32'h1);
        @(negedge clk);
        check(8, "rearm pulses end", {30'b0, rearm_fiq_o, rearm_irq_o}, 32'h0);

        // R1 soft reset
        wr_do(12'h010, 32'h0000_0002);
        check(1, "gmask_o after soft reset", 32'(gmask_o), 32'h0);
        check(1, "prio_o after soft reset", 32'(|prio_o), 32'h0);
        rd_chk(1, 12'h084, 32'hFFFF_FFFF);
        rd_chk(1, 12'h0A4, 32'hFFFF_FFFF);
        rd_chk(1, 12'h114, 32'h0000_0000);
        rd_chk(1, 12'h0B0, 32'h0000_0000);
        rd_chk(1, 12'h010, 32'h0000_0000);
        rd_chk(1, 12'h050, 32'h0000_0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule